// File: doc/BRIEF.md
# Serial Control and Status Port

This block is the host-facing register port of a line transceiver. A host processor reaches it over a four-wire serial link: an active-low select, a serial clock, a data line into the block and a data line out of it. Every access swaps one whole byte. While the new control byte shifts in, the status byte shifts out. A completed access therefore always rewrites the control register, even when the host only wanted to read status. To leave the mode unchanged, the host sends the previous control byte again.

The status byte carries three live bits. Two of them are level indications from the line side: line-signal detect and loop sync. The third is a sticky flag for line-code violations. A change in either level bit pulls an active-low interrupt output low, and that output stays low until the host starts its next access. A violation sets the sticky flag but never raises the interrupt. The flag is cleared at the end of each access, so a host can estimate the error rate by polling it.

The serial pins and the status inputs are asynchronous to the block. They are oversampled on a local clock through two-flop synchronizers. Edges of the serial clock and of the select are found in that local clock domain. A small state machine with four states tracks each access: `ST_IDLE`, `ST_SHIFT`, `ST_FULL` and `ST_OVER`. The transitions are:

- idle→shift on select fall;
- shift→full on the eighth rising serial edge;
- full→over on any further rising edge;
- any state→idle on select rise.

Top module: `serctl_port`

## Requirements
- R1: An access with exactly 8 rising `sclk` edges while `cs_n` is low commits the received byte to `ctrl` when `cs_n` rises. `sdi` is sampled on rising edges, first bit into `ctrl[7]`.
- R2: An access with fewer or more than 8 rising `sclk` edges leaves `ctrl` unchanged.
- R3: The status byte is captured when `cs_n` falls, with bit 0 = line detect, bit 1 = sync, bit 2 = violation flag and bits 7..3 = 0. It is sent MSB first on `sdo`: bit 7 is valid from the select fall, and each later bit appears after a falling `sclk` edge.
- R4: `sdo_oe` is 0 while no access is in progress and 1 during an access. `sdo` is 0 whenever `sdo_oe` is 0.
- R5: Any change of `line_det` or `sync_ok`, in either direction, drives `irq_n` low, and it stays low.
- R6: `irq_n` returns high after the first rising `sclk` edge of an access.
- R7: A pulse on `code_viol` sets the violation flag without driving `irq_n` low.
- R8: The violation flag is cleared when `cs_n` rises at the end of any access, after it has been reported.
- R9: After reset, `ctrl` is 0, `irq_n` is 1 and `sdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Host serial clock, idles low |
| cs_n | input | 1 | Host select, active low |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial status data to host |
| sdo_oe | output | 1 | Output enable for `sdo` |
| line_det | input | 1 | Line-signal detect level, asynchronous |
| sync_ok | input | 1 | Loop sync level, asynchronous |
| code_viol | input | 1 | Line-code violation indication, held at least 2 clocks |
| irq_n | output | 1 | Latched interrupt, active low |
| ctrl | output | W | Control register |

## Verification
The bench sends a short access of 5 clocks and a long access of 9 clocks. A design that counted loosely, or that committed on the last clock instead of at select release, would corrupt `ctrl` in one of these cases. The bench moves each status level in both directions and checks that the interrupt latches. It then checks that the interrupt clears once the access starts. An edge detector that sees only rising edges would miss the sync loss. Violation pulses are checked for reporting in exactly one following access and for leaving `irq_n` high. A design that routed the sticky flag into the interrupt, or cleared it before capturing it, would show up here.

// File: rtl/serctl_pkg.sv
package serctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_FULL,
        ST_OVER
    } port_state_e;

endpackage

// File: rtl/cdc_sync.sv
// Multi-bit bank of independent synchronizer chains (STAGES >= 2).
module cdc_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg <= {stg[STAGES-2:0], d};
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/port_fsm.sv
module port_fsm
    import serctl_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_fall,
    input  logic                 cs_rise,
    input  logic                 sclk_rise,
    input  logic                 sclk_fall,
    input  logic                 sdi_q,
    input  logic [W-1:0]         status_in,
    output port_state_e          st,
    output logic [$clog2(W+1)-1:0] bitcnt,
    output logic [W-1:0]         rx_byte,
    output logic                 commit,
    output logic                 first_rise,
    output logic                 sdo,
    output logic                 sdo_oe
);

    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    port_state_e st_nx;
    logic [W-1:0] tx_sh;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (cs_fall) st_nx = ST_SHIFT;
            ST_SHIFT: if (cs_rise) st_nx = ST_IDLE;
                      else if (sclk_rise && bitcnt == LAST) st_nx = ST_FULL;
            ST_FULL:  if (cs_rise) st_nx = ST_IDLE;
                      else if (sclk_rise) st_nx = ST_OVER;
            ST_OVER:  if (cs_rise) st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // Shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh   <= '0;
            rx_byte <= '0;
            bitcnt  <= '0;
        end else begin
            if (st == ST_IDLE && cs_fall) begin
                tx_sh  <= status_in;
                bitcnt <= '0;
            end else if (st != ST_IDLE) begin
                if (sclk_fall) tx_sh <= {tx_sh[W-2:0], 1'b0};
                if (st == ST_SHIFT && sclk_rise) begin
                    rx_byte <= {rx_byte[W-2:0], sdi_q};
                    bitcnt  <= bitcnt + 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        sdo_oe     = (st != ST_IDLE);
        sdo        = sdo_oe ? tx_sh[W-1] : 1'b0;
        commit     = (st == ST_FULL) && cs_rise;
        first_rise = (st == ST_SHIFT) && sclk_rise && (bitcnt == '0);
    end

endmodule

// File: rtl/irq_stat.sv
module irq_stat (
    input  logic clk,
    input  logic rst_n,
    input  logic line_q,
    input  logic sync_q,
    input  logic viol_q,
    input  logic first_rise,
    input  logic cs_rise,
    output logic stat_chg,
    output logic irq_n,
    output logic viol_flag
);

    logic line_p, sync_p;

    assign stat_chg = (line_q != line_p) || (sync_q != sync_p);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_p    <= 1'b0;
            sync_p    <= 1'b0;
            irq_n     <= 1'b1;
            viol_flag <= 1'b0;
        end else begin
            line_p <= line_q;
            sync_p <= sync_q;
            if (stat_chg)        irq_n <= 1'b0;
            else if (first_rise) irq_n <= 1'b1;
            if (viol_q)          viol_flag <= 1'b1;
            else if (cs_rise)    viol_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/serctl_port.sv
module serctl_port
    import serctl_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk,
    input  logic         cs_n,
    input  logic         sdi,
    output logic         sdo,
    output logic         sdo_oe,
    input  logic         line_det,
    input  logic         sync_ok,
    input  logic         code_viol,
    output logic         irq_n,
    output logic [W-1:0] ctrl
);

    localparam int NIN = 6;
    localparam logic [NIN-1:0] IN_RST = 6'b010000;

    logic [NIN-1:0] raw_in, syn;
    logic sclk_q, cs_q, sdi_q, line_q, sync_q, viol_q;
    logic sclk_p, cs_p;
    logic sclk_rise, sclk_fall, cs_rise, cs_fall;
    logic commit, first_rise, stat_chg, viol_flag;
    logic [W-1:0] rx_byte, status_byte;
    logic [$clog2(W+1)-1:0] bitcnt;
    port_state_e st;

    assign raw_in = {sclk, cs_n, sdi, line_det, sync_ok, code_viol};

    cdc_sync #(.W(NIN), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
    );

    assign {sclk_q, cs_q, sdi_q, line_q, sync_q, viol_q} = syn;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_p <= 1'b0;
            cs_p   <= 1'b1;
        end else begin
            sclk_p <= sclk_q;
            cs_p   <= cs_q;
        end
    end

    assign sclk_rise = sclk_q & ~sclk_p;
    assign sclk_fall = ~sclk_q & sclk_p;
    assign cs_fall   = ~cs_q & cs_p;
    assign cs_rise   = cs_q & ~cs_p;

    always_comb begin
        status_byte    = '0;
        status_byte[0] = line_q;
        status_byte[1] = sync_q;
        status_byte[2] = viol_flag;
    end

    port_fsm #(.W(W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cs_fall(cs_fall), .cs_rise(cs_rise),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .sdi_q(sdi_q), .status_in(status_byte),
        .st(st), .bitcnt(bitcnt), .rx_byte(rx_byte),
        .commit(commit), .first_rise(first_rise),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    irq_stat u_irq (
        .clk(clk), .rst_n(rst_n),
        .line_q(line_q), .sync_q(sync_q), .viol_q(viol_q),
        .first_rise(first_rise), .cs_rise(cs_rise),
        .stat_chg(stat_chg), .irq_n(irq_n), .viol_flag(viol_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctrl <= '0;
        else if (commit) ctrl <= rx_byte;
    end

endmodule

// File: rtl/serctl_port_chk.sv
module serctl_port_chk
    import serctl_pkg::*;
#(
    parameter int W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input port_state_e            st,
    input logic [$clog2(W+1)-1:0] bitcnt,
    input logic                   cs_rise,
    input logic                   cs_fall,
    input logic                   first_rise,
    input logic                   stat_chg,
    input logic                   irq_n,
    input logic                   sdo_oe,
    input logic [W-1:0]           ctrl
);

    // R1 / R2: control only moves right after a full-count select release
    a_r2_ctrl_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(ctrl) |-> ($past(st) == ST_FULL && $past(cs_rise)));

    // R1: bit counter never exceeds the byte width
    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= ($clog2(W+1))'(W));

    // R4: output enable only turns on at the start of an access
    a_r4_oe_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> $past(cs_fall));

    // R5: a status change latches the interrupt
    a_r5_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        stat_chg |=> !irq_n);

    // R6: first serial clock of an access releases the interrupt
    a_r6_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (first_rise && !stat_chg) |=> irq_n);

    // R7: nothing except a level change (never a violation) asserts it
    a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_n && !stat_chg) |=> irq_n);

endmodule

bind serctl_port serctl_port_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .bitcnt(bitcnt),
    .cs_rise(cs_rise), .cs_fall(cs_fall), .first_rise(first_rise),
    .stat_chg(stat_chg), .irq_n(irq_n), .sdo_oe(sdo_oe), .ctrl(ctrl)
);

// File: tb/sim_serctl_port.sv
module sim_serctl_port;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic sdi = 1'b0;
    logic line_det = 1'b0;
    logic sync_ok = 1'b0;
    logic code_viol = 1'b0;
    logic sdo, sdo_oe, irq_n;
    logic [7:0] ctrl;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [7:0] ctrl_m = 8'h00;
    logic line_m = 0, sync_m = 0, viol_m = 0;

    typedef struct {
        logic [7:0] st;
        logic [7:0] ct;
        int         n;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    serctl_port #(.W(8), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .line_det(line_det), .sync_ok(sync_ok),
        .code_viol(code_viol), .irq_n(irq_n), .ctrl(ctrl)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: one access with nclk serial clocks; pushes the expected outcome
    task automatic xfer(input logic [7:0] tx, input int nclk);
        exp_t e;
        e.st = {5'b0, viol_m, sync_m, line_m};
        if (nclk == 8) ctrl_m = tx;
        e.ct = ctrl_m;
        e.n  = nclk;
        sb.push_back(e);
        cs_n = 1'b0;
        waitc(8);
        check(sdo_oe == 1'b1, "R4", sdo_oe, 1);
        for (int i = 0; i < nclk; i++) begin
            sdi = (i < 8) ? tx[7-i] : 1'b0;
            waitc(8);
            sclk = 1'b1;
            waitc(8);
            sclk = 1'b0;
        end
        waitc(8);
        cs_n = 1'b1;
        viol_m = 0;
        waitc(14);
    endtask

    // Monitor: collects sdo at rising sclk, compares against the scoreboard
    initial begin
        logic [7:0] got;
        int nb;
        exp_t e;
        forever begin
            @(negedge cs_n);
            got = '0;
            nb  = 0;
            while (cs_n == 1'b0) begin
                @(posedge sclk or posedge cs_n);
                if (cs_n == 1'b0 && nb < 8) begin
                    got = {got[6:0], sdo};
                    nb++;
                end
            end
            waitc(8);
            if (sb.size() == 0) begin
                check(1'b0, "R1", 0, 1);
            end else begin
                e = sb.pop_front();
                if (e.n >= 8) check(got == e.st, "R3", got, e.st);
                if (e.n == 8) check(ctrl == e.ct, "R1", ctrl, e.ct);
                else          check(ctrl == e.ct, "R2", ctrl, e.ct);
                check(sdo_oe == 1'b0 && sdo == 1'b0, "R4", {sdo_oe, sdo}, 0);
            end
        end
    end

    initial begin
        waitc(5);
        // R9: reset state
        check(ctrl == 8'h00, "R9", ctrl, 0);
        check(irq_n == 1'b1, "R9", irq_n, 1);
        check(sdo_oe == 1'b0, "R9", sdo_oe, 0);
        rst_n = 1'b1;
        waitc(6);

        // R1: full accesses, different patterns
        xfer(8'hA5, 8);
        xfer(8'h3C, 8);
        // R2: short and long accesses leave ctrl alone
        xfer(8'hFF, 5);
        xfer(8'h00, 9);

        // R5: line detect rises
        line_det = 1'b1; line_m = 1;
        waitc(10);
        check(irq_n == 1'b0, "R5", irq_n, 0);
        waitc(20);
        check(irq_n == 1'b0, "R5", irq_n, 0);
        // R6: access clears it
        xfer(8'h81, 8);
        check(irq_n == 1'b1, "R6", irq_n, 1);

        // R5: sync rises, then falls
        sync_ok = 1'b1; sync_m = 1;
        waitc(10);
        check(irq_n == 1'b0, "R5", irq_n, 0);
        xfer(8'h5A, 8);
        check(irq_n == 1'b1, "R6", irq_n, 1);
        sync_ok = 1'b0; sync_m = 0;
        waitc(10);
        check(irq_n == 1'b0, "R5", irq_n, 0);
        xfer(8'h0F, 8);
        check(irq_n == 1'b1, "R6", irq_n, 1);

        // R7: violation sets the flag, no interrupt
        code_viol = 1'b1;
        waitc(4);
        code_viol = 1'b0;
        viol_m = 1;
        waitc(10);
        check(irq_n == 1'b1, "R7", irq_n, 1);
        xfer(8'hC3, 8);
        // R8: flag cleared by the previous access
        xfer(8'hC3, 8);
        // R8: an aborted access also clears it
        code_viol = 1'b1;
        waitc(4);
        code_viol = 1'b0;
        viol_m = 1;
        waitc(10);
        xfer(8'h11, 3);
        xfer(8'h96, 8);

        waitc(20);
        check(sb.size() == 0, "R1", sb.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule